// File: doc/BRIEF.md
# Multiplexed ADC Capture Sequencer

The sequencer paces a pipelined analog-to-digital converter that samples the output of an analog multiplexer. It runs on the conversion clock and splits the conversion stream into groups of four. At the start of each group it drives a new channel address to the multiplexer. Only the second conversion of each group is kept, so the multiplexer has a full conversion period to settle after the address change before a result is trusted. The other three conversions are discarded.

The converter has a fixed pipeline latency. The block tags every conversion with its group position and channel, and delays that tag by the latency. When the kept result reaches the converter's output, the block registers the 14-bit straight-binary word, the channel it belongs to and an overflow class. In the same clock edge it raises a one-cycle request toward a DMA engine. The overflow class combines the out-of-range flag with the sample's most significant bit, which tells an overflow above full scale apart from one below zero.

Top module: `adc_capture_seq`

## Requirements
- R1: While rst_n is low, mux_addr, cap_data, cap_chan, cap_range and dma_req are all zero.
- R2: Time is counted in conversion periods, one per clock. Period 0 begins at the second rising edge after rst_n goes high. Period p holds group position p mod 4, and a group is four consecutive periods starting at a multiple of 4.
- R3: mux_addr is 0 during periods 0 to 3. At the edge that ends the last period of a group, it loads next_chan. It holds that value for the whole of the following group.
- R4: dma_req is high for exactly one clock per group and low otherwise. Two consecutive pulses are four clocks apart.
- R5: The conversion started in period j appears on adc_data during period j+3. When j is at group position 1, cap_data takes that word at the edge ending period j+3, and dma_req is high during period j+4.
- R6: With each pulse, cap_chan equals the mux_addr that was in effect during period j of the kept conversion.
- R7: cap_range is 2'b01 (over range) when the kept word had adc_otr set and bit 13 set. It is 2'b10 (under range) when adc_otr was set and bit 13 clear. It is 2'b00 when adc_otr was clear.
- R8: Results of conversions at group positions 0, 2 and 3 are ignored. cap_data, cap_chan and cap_range keep their values in every period in which dma_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| adc_data | input | 14 | Straight-binary converter output |
| adc_otr | input | 1 | Converter out-of-range flag |
| next_chan | input | 4 | Channel to select for the next group |
| mux_addr | output | 4 | Analog multiplexer address |
| cap_data | output | 14 | Latched kept sample |
| cap_chan | output | 4 | Channel of the latched sample |
| cap_range | output | 2 | Overflow class of the latched sample |
| dma_req | output | 1 | One-cycle DMA request strobe |

## Verification
A new mux_addr is due one clock after the last period of a group, and becomes visible in the first period of the next group. A kept result is due LAT+1 = 4 periods after its conversion starts: three periods of converter latency, then one register. The bench drives inputs and samples outputs at the falling edge of each period. At period p it compares the outputs with the data it drove in period p-1 and with the channel it expects for period p-4. Every period is checked, so an early, late or missing pulse is caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    RNG_OK    = 2'b00,
    RNG_OVER  = 2'b01,
    RNG_UNDER = 2'b10
  } range_e;

  function automatic range_e classify(input logic otr, input logic msb);
    if (!otr)    return RNG_OK;
    else if (msb) return RNG_OVER;
    else          return RNG_UNDER;
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/seq_group_timer.sv
module seq_group_timer #(
  parameter int GROUP  = 4,
  parameter int ADDR_W = 4,
  localparam int PH_W  = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] next_chan,
  output logic [PH_W-1:0]   phase,
  output logic [ADDR_W-1:0] mux_addr
);
  localparam logic [PH_W-1:0] LAST = PH_W'(GROUP - 1);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [ADDR_W-1:0] mux_q, mux_d;
  logic              mux_en;

  always_comb begin
    mux_en  = (phase_q == LAST);
    phase_d = mux_en ? '0 : phase_q + 1'b1;
    mux_d   = mux_en ? next_chan : mux_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      mux_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (mux_en) mux_q <= mux_d;
    end
  end

  assign phase    = phase_q;
  assign mux_addr = mux_q;

  p_mux_group_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_q) |-> (phase_q == '0));

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == LAST) |-> (phase_q == '0));
endmodule

// File: rtl/seq_tag_pipe.sv
module seq_tag_pipe #(
  parameter int GROUP  = 4,
  parameter int KEEP   = 1,
  parameter int LAT    = 3,
  parameter int ADDR_W = 4,
  localparam int PH_W  = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase,
  input  logic [ADDR_W-1:0] chan,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_chan
);
  localparam logic [PH_W-1:0] KEEP_PH = PH_W'(KEEP);

  logic [LAT-1:0]    keep_q;
  logic [ADDR_W-1:0] chan_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q[0] <= 1'b0;
      chan_q[0] <= '0;
    end else begin
      keep_q[0] <= (phase == KEEP_PH);
      chan_q[0] <= chan;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keep_q[s] <= 1'b0;
        chan_q[s] <= '0;
      end else begin
        keep_q[s] <= keep_q[s-1];
        chan_q[s] <= chan_q[s-1];
      end
    end
  end

  assign hit      = keep_q[LAT-1];
  assign hit_chan = chan_q[LAT-1];

  p_tag_sparse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    keep_q[0] |=> !keep_q[0]);
endmodule

// File: rtl/seq_capture.sv
module seq_capture
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_chan,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_otr,
  output logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] cap_chan,
  output range_e            cap_range,
  output logic              dma_req
);
  logic [DATA_W-1:0] data_q, data_d;
  logic [ADDR_W-1:0] chan_q, chan_d;
  range_e            rng_q, rng_d;
  logic              req_q, req_d;

  always_comb begin
    data_d = data_q;
    chan_d = chan_q;
    rng_d  = rng_q;
    req_d  = hit;
    if (hit) begin
      data_d = adc_data;
      chan_d = hit_chan;
      rng_d  = classify(adc_otr, adc_data[DATA_W-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      chan_q <= '0;
      rng_q  <= RNG_OK;
      req_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (hit) begin
        data_q <= data_d;
        chan_q <= chan_d;
        rng_q  <= rng_d;
      end
    end
  end

  assign cap_data  = data_q;
  assign cap_chan  = chan_q;
  assign cap_range = rng_q;
  assign dma_req   = req_q;

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(data_q) && $stable(chan_q) && $stable(rng_q)));

  p_latch_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (data_q == $past(adc_data)));
endmodule

// File: rtl/adc_capture_seq.sv
module adc_capture_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 4,
  parameter int GROUP  = 4,
  parameter int KEEP   = 1,
  parameter int LAT    = 3,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              adc_otr,
  input  logic [ADDR_W-1:0] next_chan,
  output logic [ADDR_W-1:0] mux_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] cap_chan,
  output logic [1:0]        cap_range,
  output logic              dma_req
);
  localparam int PH_W  = $clog2(GROUP);
  localparam int GAP_W = $clog2(GROUP) + 2;

  logic              rst_int_n;
  logic [PH_W-1:0]   phase;
  logic              hit;
  logic [ADDR_W-1:0] hit_chan;
  range_e            rng;

  seq_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  seq_group_timer #(.GROUP(GROUP), .ADDR_W(ADDR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .next_chan (next_chan),
    .phase     (phase),
    .mux_addr  (mux_addr)
  );

  seq_tag_pipe #(.GROUP(GROUP), .KEEP(KEEP), .LAT(LAT), .ADDR_W(ADDR_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .phase    (phase),
    .chan     (mux_addr),
    .hit      (hit),
    .hit_chan (hit_chan)
  );

  seq_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hit       (hit),
    .hit_chan  (hit_chan),
    .adc_data  (adc_data),
    .adc_otr   (adc_otr),
    .cap_data  (cap_data),
    .cap_chan  (cap_chan),
    .cap_range (rng),
    .dma_req   (dma_req)
  );

  assign cap_range = rng;

  // spacing monitor for the request strobe
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (dma_req) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_req_spacing_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dma_req && seen_q) |-> (gap_q == GAP_W'(GROUP - 1)));

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    dma_req |=> !dma_req);

  p_over_sign_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cap_range == 2'b01) |-> cap_data[DATA_W-1]);

  p_under_sign_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cap_range == 2'b10) |-> !cap_data[DATA_W-1]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!dma_req && mux_addr == '0));
endmodule

// File: tb/sim_adc_capture_seq.sv
`timescale 1ns/1ps
module sim_adc_capture_seq;
  localparam int LAT = 3;
  localparam int NP  = 800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] adc_data;
  logic        adc_otr;
  logic [3:0]  next_chan;
  logic [3:0]  mux_addr;
  logic [13:0] cap_data;
  logic [3:0]  cap_chan;
  logic [1:0]  cap_range;
  logic        dma_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [13:0] dv [NP];
  logic        ov [NP];
  logic [3:0]  nc [NP];

  always #2.5 clk = ~clk;

  adc_capture_seq u0 (
    .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_otr(adc_otr),
    .next_chan(next_chan), .mux_addr(mux_addr), .cap_data(cap_data),
    .cap_chan(cap_chan), .cap_range(cap_range), .dma_req(dma_req)
  );

  function automatic logic [3:0] mux_exp(input int p);
    if (p < 4) return 4'd0;
    return nc[(p / 4) * 4 - 1];
  endfunction

  function automatic logic [1:0] range_exp(input logic [13:0] d, input logic o);
    if (!o) return 2'b00;
    return d[13] ? 2'b01 : 2'b10;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] last_d;
    logic [3:0]  last_c;
    logic [1:0]  last_r;
    void'($urandom(32'd4242));
    rst_n = 1'b0; adc_data = '0; adc_otr = 1'b0; next_chan = '0;
    repeat (3) @(negedge clk);
    adc_data = 14'h3FFF; adc_otr = 1'b1; next_chan = 4'hF;
    @(negedge clk);
    // R1 reset state
    check("R1 mux_addr", 32'(mux_addr), 0);
    check("R1 cap_data", 32'(cap_data), 0);
    check("R1 cap_chan", 32'(cap_chan), 0);
    check("R1 cap_range", 32'(cap_range), 0);
    check("R1 dma_req", 32'(dma_req), 0);
    rst_n = 1'b1;
    @(negedge clk);           // after first edge: synchronizer filling
    check("R1 dma_req sync", 32'(dma_req), 0);
    last_d = '0; last_c = '0; last_r = '0;
    for (int p = 0; p < NP; p++) begin
      int j;
      @(negedge clk);         // middle of period p
      // R2/R3 address in effect for this period
      check("R3 mux_addr", 32'(mux_addr), 32'(mux_exp(p)));
      j = p - 1 - LAT;
      if (j >= 0 && (j % 4) == 1) begin
        check("R4 dma_req high", 32'(dma_req), 1);
        check("R5 cap_data", 32'(cap_data), 32'(dv[p-1]));
        check("R6 cap_chan", 32'(cap_chan), 32'(mux_exp(j)));
        check("R7 cap_range", 32'(cap_range), 32'(range_exp(dv[p-1], ov[p-1])));
        last_d = dv[p-1]; last_c = mux_exp(j); last_r = range_exp(dv[p-1], ov[p-1]);
      end else begin
        check("R4 dma_req low", 32'(dma_req), 0);
        check("R8 cap_data held", 32'(cap_data), 32'(last_d));
        check("R8 cap_chan held", 32'(cap_chan), 32'(last_c));
        check("R8 cap_range held", 32'(cap_range), 32'(last_r));
      end
      // drive this period's converter output and next channel
      case (p % 40)
        6:  begin dv[p] = 14'h3FFF; ov[p] = 1'b1; end
        14: begin dv[p] = 14'h0000; ov[p] = 1'b1; end
        22: begin dv[p] = 14'h2000; ov[p] = 1'b0; end
        30: begin dv[p] = 14'h1FFF; ov[p] = 1'b1; end
        default: begin
          dv[p] = 14'($urandom);
          ov[p] = ($urandom % 3) == 0;
        end
      endcase
      nc[p] = 4'($urandom);
      adc_data  = dv[p];
      adc_otr   = ov[p];
      next_chan = nc[p];
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule